// File: doc/BRIEF.md
# BCD Calendar Counter with Snapshot

This block is the counting core of a real-time clock. It keeps seconds, minutes, hours, day of month, month, two-digit year and weekday, each held in packed BCD (the weekday as a plain 0 to 6 count). A one-cycle tick input, pulsed once per second by the surrounding logic, advances the calendar while the run bit in the control register is set. Day rollover follows the length of the current month and a leap-year rule in which every year divisible by four has a 29-day February.

Software reaches the block through a byte-wide register port with a combinational read path. To set the time it clears the run bit, writes the seven time registers and sets run again. To read the time coherently while the clock keeps going, it sets the snapshot bit, which copies all live counters into shadow latches in that same cycle, and sets the view bit so that time-register reads return the latched copy. Four event pulses (second, minute, hour, day) are produced, and sticky copies of them sit in the status register beside a running flag.

Top module: `bcd_rtc_core`

## Requirements
- R1: After reset the time reads 00:00:00, day 0x01, month 0x01, year 0x00, weekday 0; the control register (offset 0x10) and the status register (offset 0x11) read 0x00.
- R2: While control bit 0 is 0, ticks change no counter and raise no event output.
- R3: While control bit 0 is 0, a write to offset 0x00 (seconds), 0x01 (minutes), 0x02 (hours), 0x03 (day), 0x04 (month), 0x05 (year) or 0x06 (weekday, bits 2:0) loads that counter, and a read of the same offset returns it.
- R4: While control bit 0 is 1, each tick raises the seconds by one in BCD, visible in the cycle after the tick, and writes to offsets 0x00 to 0x06 are ignored.
- R5: Seconds and minutes roll 0x59 to 0x00, hours 0x23 to 0x00, month 0x12 to 0x01, year 0x99 to 0x00, and the weekday steps with every day change, 6 wrapping to 0.
- R6: The day rolls to 0x01 after day 0x30 in months 0x04, 0x06, 0x09, 0x11; after 0x29 in month 0x02 when the year is divisible by four, else after 0x28; after 0x31 in every other month.
- R7: ev_sec is high for exactly one cycle after each counted tick; ev_min, ev_hour and ev_day are high in that same cycle only when minutes, hours or day change with that tick.
- R8: Control bit 0 is run, bit 6 is snapshot, bit 7 is view-shadow; these bits read back as written and all other control bits read 0.
- R9: A control write with bit 6 set copies the live counters (values before any tick of that cycle) into the shadow; with bit 7 set, reads of 0x00 to 0x06 return the shadow, otherwise the live counters.
- R10: Status bit 1 equals the run bit; status bits 2, 3, 4, 5 are sticky flags of the second, minute, hour and day events, each cleared by writing 1 to it at 0x11.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_1hz | input | 1 | One-cycle pulse per second |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W | Register offset |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from bus_addr |
| ev_sec | output | 1 | Second event pulse |
| ev_min | output | 1 | Minute event pulse |
| ev_hour | output | 1 | Hour event pulse |
| ev_day | output | 1 | Day event pulse |

## Verification
Every register write and every counted tick takes effect at the one clock edge on which it is presented, so counter values, shadow contents, control and status bits and the event pulses are all due in the cycle right after that edge, while reads are combinational in the cycle the offset is applied. The bench drives inputs on the falling edge, holds them across one rising edge, and samples events and read data shortly after the next falling edge, which places every check in the first cycle the result is due; event outputs are sampled once more a cycle later to confirm they have dropped.

// File: rtl/rtc_cal_pkg.sv
package rtc_cal_pkg;
   localparam int BYTE_W = 8;
   localparam int NFLD   = 6;

   function automatic logic [BYTE_W-1:0] bcd_inc(input logic [BYTE_W-1:0] v);
      if (v[3:0] >= 4'd9) return {v[7:4] + 4'd1, 4'd0};
      return v + 8'd1;
   endfunction

   // divisible by four: even tens with units 0/4/8, odd tens with units 2/6
   function automatic logic bcd_leap(input logic [BYTE_W-1:0] y);
      if (!y[4]) return (y[3:0] == 4'd0) || (y[3:0] == 4'd4) || (y[3:0] == 4'd8);
      return (y[3:0] == 4'd2) || (y[3:0] == 4'd6);
   endfunction

   // day and month start at 1, the others at 0
   function automatic logic [BYTE_W-1:0] fld_low(input int i);
      return (i == 3 || i == 4) ? 8'h01 : 8'h00;
   endfunction
endpackage

// File: rtl/rtc_bcd_field.sv
module rtc_bcd_field
   import rtc_cal_pkg::*;
#(
   parameter logic [BYTE_W-1:0] LOW = 8'h00
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              step,
   input  logic              ld,
   input  logic [BYTE_W-1:0] ld_val,
   input  logic [BYTE_W-1:0] top,
   output logic [BYTE_W-1:0] val,
   output logic              carry
);
   logic at_top;
   assign at_top = (val >= top);
   assign carry  = step && at_top;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    val <= LOW;
      else if (ld)   val <= ld_val;
      else if (step) val <= at_top ? LOW : bcd_inc(val);
   end
endmodule

// File: rtl/rtc_month_len.sv
module rtc_month_len
   import rtc_cal_pkg::*;
(
   input  logic [BYTE_W-1:0] month,
   input  logic [BYTE_W-1:0] year,
   output logic [BYTE_W-1:0] last_day
);
   always_comb begin
      unique case (month)
         8'h02:                      last_day = bcd_leap(year) ? 8'h29 : 8'h28;
         8'h04, 8'h06, 8'h09, 8'h11: last_day = 8'h30;
         default:                    last_day = 8'h31;
      endcase
   end
endmodule

// File: rtl/bcd_rtc_core.sv
module bcd_rtc_core
   import rtc_cal_pkg::*;
#(
   parameter int               ADDR_W    = 5,
   parameter logic [ADDR_W-1:0] CTRL_OFS = 5'h10,
   parameter logic [ADDR_W-1:0] STAT_OFS = 5'h11,
   parameter int               WDAY_LAST = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick_1hz,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [7:0]        bus_wdata,
   output logic [7:0]        bus_rdata,
   output logic              ev_sec,
   output logic              ev_min,
   output logic              ev_hour,
   output logic              ev_day
);
   localparam int WD_W = $clog2(WDAY_LAST + 1);
   localparam logic [ADDR_W-1:0] WDAY_OFS = ADDR_W'(NFLD);

   generate
      if (ADDR_W < 3)                 begin : g_chk_aw  $error("ADDR_W too small"); end
      if (CTRL_OFS == STAT_OFS)       begin : g_chk_ofs $error("control and status overlap"); end
      if (CTRL_OFS <= WDAY_OFS)       begin : g_chk_c   $error("control overlaps time registers"); end
      if (STAT_OFS <= WDAY_OFS)       begin : g_chk_s   $error("status overlaps time registers"); end
      if (WDAY_LAST < 1 || WDAY_LAST > 9) begin : g_chk_wd $error("WDAY_LAST out of range"); end
   endgenerate

   // control and status state
   logic run, snap, view;
   logic [3:0] ev_flag;

   // counting chain
   logic            step [NFLD+1];
   logic [7:0]      live [NFLD];
   logic [7:0]      shadow [NFLD];
   logic [7:0]      fld_top [NFLD];
   logic            ld [NFLD];
   logic [WD_W-1:0] wday, wday_sh;
   logic [7:0]      mon_last;

   logic wr_time, wr_ctrl, wr_stat;
   assign wr_time = bus_wr && !run;
   assign wr_ctrl = bus_wr && (bus_addr == CTRL_OFS);
   assign wr_stat = bus_wr && (bus_addr == STAT_OFS);

   assign step[0] = tick_1hz && run;

   rtc_month_len u_len (
      .month    (live[4]),
      .year     (live[5]),
      .last_day (mon_last)
   );

   always_comb begin
      fld_top[0] = 8'h59;
      fld_top[1] = 8'h59;
      fld_top[2] = 8'h23;
      fld_top[3] = mon_last;
      fld_top[4] = 8'h12;
      fld_top[5] = 8'h99;
   end

   for (genvar i = 0; i < NFLD; i++) begin : g_fld
      assign ld[i] = wr_time && (bus_addr == ADDR_W'(i));
      rtc_bcd_field #(.LOW(fld_low(i))) u_f (
         .clk    (clk),
         .rst_n  (rst_n),
         .step   (step[i]),
         .ld     (ld[i]),
         .ld_val (bus_wdata),
         .top    (fld_top[i]),
         .val    (live[i]),
         .carry  (step[i+1])
      );
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                         shadow[i] <= fld_low(i);
         else if (wr_ctrl && bus_wdata[6])   shadow[i] <= live[i];
      end
   end

   // weekday advances together with the day field
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                  wday <= '0;
      else if (wr_time && bus_addr == WDAY_OFS)    wday <= bus_wdata[WD_W-1:0];
      else if (step[3])                            wday <= (wday >= WD_W'(WDAY_LAST)) ? '0 : wday + 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                        wday_sh <= '0;
      else if (wr_ctrl && bus_wdata[6])  wday_sh <= wday;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run  <= 1'b0;
         snap <= 1'b0;
         view <= 1'b0;
      end else if (wr_ctrl) begin
         run  <= bus_wdata[0];
         snap <= bus_wdata[6];
         view <= bus_wdata[7];
      end
   end

   logic [3:0] ev_now;
   assign ev_now = {step[4], step[3], step[2], step[1]};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ev_flag <= '0;
         ev_sec  <= 1'b0;
         ev_min  <= 1'b0;
         ev_hour <= 1'b0;
         ev_day  <= 1'b0;
      end else begin
         ev_flag <= (wr_stat ? (ev_flag & ~bus_wdata[5:2]) : ev_flag)
                    | {ev_now[2:0], step[0]};
         ev_sec  <= step[0];
         ev_min  <= step[1];
         ev_hour <= step[2];
         ev_day  <= step[3];
      end
   end

   always_comb begin
      bus_rdata = '0;
      for (int k = 0; k < NFLD; k++)
         if (bus_addr == ADDR_W'(k)) bus_rdata = view ? shadow[k] : live[k];
      if (bus_addr == WDAY_OFS) bus_rdata = 8'(view ? wday_sh : wday);
      if (bus_addr == CTRL_OFS) bus_rdata = {view, snap, 5'b0, run};
      if (bus_addr == STAT_OFS) bus_rdata = {2'b0, ev_flag, run, 1'b0};
   end
endmodule

module rtc_core_chk #(
   parameter int               ADDR_W   = 5,
   parameter logic [ADDR_W-1:0] CTRL_OFS = 5'h10
) (
   input logic              clk,
   input logic              rst_n,
   input logic              tick_1hz,
   input logic              run,
   input logic              bus_wr,
   input logic [ADDR_W-1:0] bus_addr,
   input logic [7:0]        bus_wdata,
   input logic [7:0]        sec_live,
   input logic [7:0]        sec_shadow,
   input logic              ev_sec,
   input logic              ev_min
);
   AST_STOP_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (!run && !(bus_wr && bus_addr == '0)) |=> $stable(sec_live)); // R2
   AST_STOP_NO_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
      !run |=> !ev_sec); // R2
   AST_RUN_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
      (run && !tick_1hz && bus_wr && bus_addr == '0) |=> $stable(sec_live)); // R4
   AST_SEC_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      (run && tick_1hz) |=> ev_sec); // R7
   AST_MIN_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      ev_min |-> (ev_sec && sec_live == 8'h00)); // R5
   AST_SNAP_COPY: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == CTRL_OFS && bus_wdata[6]) |=> (sec_shadow == $past(sec_live))); // R9
endmodule

bind bcd_rtc_core rtc_core_chk #(.ADDR_W(ADDR_W), .CTRL_OFS(CTRL_OFS)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .tick_1hz   (tick_1hz),
   .run        (run),
   .bus_wr     (bus_wr),
   .bus_addr   (bus_addr),
   .bus_wdata  (bus_wdata),
   .sec_live   (live[0]),
   .sec_shadow (shadow[0]),
   .ev_sec     (ev_sec),
   .ev_min     (ev_min)
);

// File: tb/sim_bcd_rtc_core.sv
`timescale 1ns/1ps
module sim_bcd_rtc_core;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tick_1hz = 1'b0;
   logic       bus_wr = 1'b0;
   logic [4:0] bus_addr = '0;
   logic [7:0] bus_wdata = '0;
   logic [7:0] bus_rdata;
   logic       ev_sec, ev_min, ev_hour, ev_day;

   int n_cmp = 0;
   int n_bad = 0;

   always #5 clk = ~clk;

   bcd_rtc_core u0 (.*);

   task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
      n_cmp++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s: got %02h expected %02h", tag, got, exp);
      end
   endtask

   task automatic wr(input logic [4:0] a, input logic [7:0] d);
      @(negedge clk);
      bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic rd(input logic [4:0] a, output logic [7:0] d);
      @(negedge clk);
      bus_addr = a;
      #1 d = bus_rdata;
   endtask

   task automatic rd_chk(input string tag, input logic [4:0] a, input logic [7:0] exp);
      logic [7:0] d;
      rd(a, d);
      check(tag, d, exp);
   endtask

   // one tick; returns the event outputs in the cycle after it
   task automatic tick(output logic [3:0] ev);
      @(negedge clk);
      tick_1hz = 1'b1;
      @(negedge clk);
      tick_1hz = 1'b0;
      #1 ev = {ev_day, ev_hour, ev_min, ev_sec};
   endtask

   task automatic ticks(input int n);
      logic [3:0] ev;
      for (int i = 0; i < n; i++) tick(ev);
   endtask

   task automatic set_time(input logic [7:0] s, m, h, d, mo, y, w);
      wr(5'h10, 8'h00);
      wr(5'h00, s); wr(5'h01, m); wr(5'h02, h);
      wr(5'h03, d); wr(5'h04, mo); wr(5'h05, y); wr(5'h06, w);
   endtask

   task automatic t_reset;
      rd_chk("R1 sec",   5'h00, 8'h00);
      rd_chk("R1 min",   5'h01, 8'h00);
      rd_chk("R1 hour",  5'h02, 8'h00);
      rd_chk("R1 day",   5'h03, 8'h01);
      rd_chk("R1 month", 5'h04, 8'h01);
      rd_chk("R1 year",  5'h05, 8'h00);
      rd_chk("R1 wday",  5'h06, 8'h00);
      rd_chk("R1 ctrl",  5'h10, 8'h00);
      rd_chk("R1 stat",  5'h11, 8'h00);
   endtask

   task automatic t_stopped;
      logic [3:0] ev;
      tick(ev);
      check("R2 no event while stopped", {4'h0, ev}, 8'h00);
      ticks(3);
      rd_chk("R2 sec frozen", 5'h00, 8'h00);
   endtask

   task automatic t_load;
      set_time(8'h45, 8'h17, 8'h09, 8'h22, 8'h07, 8'h31, 8'h03);
      rd_chk("R3 sec",   5'h00, 8'h45);
      rd_chk("R3 min",   5'h01, 8'h17);
      rd_chk("R3 hour",  5'h02, 8'h09);
      rd_chk("R3 day",   5'h03, 8'h22);
      rd_chk("R3 month", 5'h04, 8'h07);
      rd_chk("R3 year",  5'h05, 8'h31);
      rd_chk("R3 wday",  5'h06, 8'h03);
   endtask

   task automatic t_ctrl_bits;
      wr(5'h10, 8'h3E);
      rd_chk("R8 unused ctrl bits read 0", 5'h10, 8'h00);
   endtask

   task automatic t_count;
      logic [3:0] ev;
      wr(5'h10, 8'h01);
      rd_chk("R8 run bit", 5'h10, 8'h01);
      wr(5'h11, 8'h3C);
      rd_chk("R10 running flag", 5'h11, 8'h02);
      tick(ev);
      check("R7 sec event only", {4'h0, ev}, 8'h01);
      rd_chk("R4 sec +1", 5'h00, 8'h46);
      #1 check("R7 pulse one cycle", {7'h0, ev_sec}, 8'h00);
      rd_chk("R10 sec flag sticky", 5'h11, 8'h06);
      wr(5'h11, 8'h04);
      rd_chk("R10 flag cleared", 5'h11, 8'h02);
      ticks(4);
      rd_chk("R4 BCD digit carry", 5'h00, 8'h50);
      wr(5'h00, 8'h33);
      rd_chk("R4 write ignored while running", 5'h00, 8'h50);
      wr(5'h06, 8'h01);
      rd_chk("R4 wday write ignored", 5'h06, 8'h03);
   endtask

   task automatic t_cascade;
      logic [3:0] ev;
      set_time(8'h59, 8'h59, 8'h23, 8'h31, 8'h12, 8'h99, 8'h06);
      wr(5'h10, 8'h01);
      wr(5'h11, 8'h3C);
      tick(ev);
      check("R7 all events", {4'h0, ev}, 8'h0F);
      rd_chk("R5 sec wrap",   5'h00, 8'h00);
      rd_chk("R5 min wrap",   5'h01, 8'h00);
      rd_chk("R5 hour wrap",  5'h02, 8'h00);
      rd_chk("R5 day wrap",   5'h03, 8'h01);
      rd_chk("R5 month wrap", 5'h04, 8'h01);
      rd_chk("R5 year wrap",  5'h05, 8'h00);
      rd_chk("R5 wday wrap",  5'h06, 8'h00);
      rd_chk("R10 all flags", 5'h11, 8'h3E);
      set_time(8'h59, 8'h10, 8'h05, 8'h04, 8'h04, 8'h04, 8'h02);
      wr(5'h10, 8'h01);
      tick(ev);
      check("R7 minute only", {4'h0, ev}, 8'h03);
      rd_chk("R5 min step", 5'h01, 8'h11);
   endtask

   task automatic day_step(input string tag, input logic [7:0] d, mo, y,
                           input logic [7:0] exp_d, exp_mo);
      set_time(8'h59, 8'h59, 8'h23, d, mo, y, 8'h02);
      wr(5'h10, 8'h01);
      ticks(1);
      rd_chk({tag, " day"}, 5'h03, exp_d);
      rd_chk({tag, " month"}, 5'h04, exp_mo);
   endtask

   task automatic t_month_len;
      day_step("R6 Feb non-leap",    8'h28, 8'h02, 8'h23, 8'h01, 8'h03);
      day_step("R6 Feb leap 24",     8'h28, 8'h02, 8'h24, 8'h29, 8'h02);
      day_step("R6 Feb 29 end",      8'h29, 8'h02, 8'h24, 8'h01, 8'h03);
      day_step("R6 Feb leap 12",     8'h28, 8'h02, 8'h12, 8'h29, 8'h02);
      day_step("R6 Feb leap 00",     8'h28, 8'h02, 8'h00, 8'h29, 8'h02);
      day_step("R6 Apr 30 end",      8'h30, 8'h04, 8'h10, 8'h01, 8'h05);
      day_step("R6 Nov 30 end",      8'h30, 8'h11, 8'h10, 8'h01, 8'h12);
      day_step("R6 Jan 30 to 31",    8'h30, 8'h01, 8'h10, 8'h31, 8'h01);
      day_step("R6 Aug 31 end",      8'h31, 8'h08, 8'h10, 8'h01, 8'h09);
      rd_chk("R5 wday follows day", 5'h06, 8'h03);
   endtask

   task automatic t_snapshot;
      set_time(8'h10, 8'h20, 8'h08, 8'h05, 8'h06, 8'h15, 8'h04);
      wr(5'h10, 8'h01);
      ticks(2);
      wr(5'h10, 8'h41);
      rd_chk("R8 snapshot bit holds", 5'h10, 8'h41);
      ticks(3);
      wr(5'h10, 8'h81);
      rd_chk("R9 shadow sec", 5'h00, 8'h12);
      rd_chk("R9 shadow min", 5'h01, 8'h20);
      rd_chk("R9 shadow wday", 5'h06, 8'h04);
      rd_chk("R8 view bit", 5'h10, 8'h81);
      wr(5'h10, 8'h01);
      rd_chk("R9 live sec", 5'h00, 8'h15);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_stopped();
      t_load();
      t_ctrl_bits();
      t_count();
      t_cascade();
      t_month_len();
      t_snapshot();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      #1_000_000;
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule